// File: doc/BRIEF.md
# Ethernet MAC Link Bring-Up Sequencer

This block is a small AXI4-Lite master that brings up the link of a 100G-class Ethernet MAC core. It drives the core only through the core's register port. After reset it makes the transmitter send remote fault indications with TX disabled, and enables the receiver. It then polls the RX status word until the aligned flag appears. At that point it releases the remote-fault request and enables the transmitter, in one write. It keeps polling until the remote fault flag is clear, and then it raises `link_up`. While the link is up it keeps polling. If alignment is lost, it takes the link down, forces remote fault again and goes back to polling for alignment.

Only the aligned flag decides progress out of alignment polling. Other status bits, such as a remote fault still being reported, do not hold the sequence back. Because the remote-fault request is released as part of the sequence, a TX-to-RX loopback cannot stay stuck reporting remote fault. A write answered with any response other than OKAY, or a poll phase that runs out of attempts, sets a sticky fault flag and restarts the whole sequence.

The states, in order, are:
- `S_RESET`
- `S_TX_RFI` (write TX control: send-RFI on, TX off)
- `S_RX_EN` (write RX control: RX on)
- `S_ALIGN_GAP` / `S_ALIGN_RD` (wait, then read status, until aligned)
- `S_TX_EN` (write TX control: TX on, send-RFI off)
- `S_RF_GAP` / `S_RF_RD` (wait, then read status, until remote fault is clear)
- `S_UP_GAP` / `S_UP_RD` (link up, keep watching alignment)
- `S_TX_DROP` (write TX control: send-RFI on, TX off, then back to `S_ALIGN_GAP`)

Every write state moves to `S_RESET` on a bad response. Each read state moves to `S_RESET` when its poll budget is used up.

Top module: `link_bringup_seq`

## Requirements
- R1: While `rst_n` is low, `link_up`, `link_fault`, `last_status` and every VALID output are 0.
- R2: After reset the first transaction writes 0x10 (bit 4 send-RFI set, bit 0 TX enable clear) to the TX control offset (default 0x000C). The second writes 0x01 (bit 0 RX enable) to the RX control offset (default 0x0014). Both happen before any read.
- R3: Every read targets byte offset 0x0204. `last_status` holds the data of the most recent completed read.
- R4: Polling leaves the alignment phase when bit 1 of the status word is 1, whatever the other bits are. For example, 0x23 and 0x02 count as aligned, and 0x01 and 0xFFFD do not.
- R5: The transaction right after the aligned read writes 0x01 to the TX control offset: TX enable set, send-RFI clear.
- R6: `link_up` rises only after a read with bit 1 = 1 and bit 5 (remote fault) = 0. While bit 5 stays 1, `link_up` stays 0 and polling goes on.
- R7: Two consecutive status reads are at least 16 clocks apart. The spacing is max(POLL_GAP, 16) wait cycles plus the transaction.
- R8: If POLL_LIMIT consecutive polls in one phase fail, `link_fault` is set and the sequence restarts with the send-RFI write.
- R9: A write response other than OKAY (0b00) sets `link_fault` and restarts the sequence with the send-RFI write.
- R10: `link_fault` stays 1 until reset, even after a later successful bring-up.
- R11: At most one transaction is outstanding. AWVALID and WVALID rise together. Each VALID, with its address and data, is held until its READY.
- R12: While the link is up, a read with bit 1 = 0 clears `link_up`, writes 0x10 to the TX control offset and resumes alignment polling, so that link-up can be regained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Write byte address |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write strobes (all set) |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | ADDR_W | Read byte address |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response code |
| link_up | output | 1 | Link is declared up |
| link_fault | output | 1 | Sticky fault (timeout or bad write response) |
| last_status | output | DATA_W | Last RX status word read |

## Verification
The bench builds the block with POLL_GAP = 16 and POLL_LIMIT = 8. With these values one poll takes about twenty clocks, so a phase that never succeeds times out within a couple of hundred cycles. This makes the restart paths for timeout and for a bad write response reachable in a short run. The register model in the bench delays READY by one or two cycles, which exercises VALID holding. Its status word can be changed at any time, which drives alignment loss and a lingering remote fault.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    typedef enum logic [3:0] {
        S_RESET,
        S_TX_RFI,
        S_RX_EN,
        S_ALIGN_GAP,
        S_ALIGN_RD,
        S_TX_EN,
        S_RF_GAP,
        S_RF_RD,
        S_UP_GAP,
        S_UP_RD,
        S_TX_DROP
    } seq_state_e;

    typedef enum logic [1:0] {
        M_IDLE,
        M_ADDR,
        M_RESP
    } axm_state_e;

    // Status word bit positions (decoded by the core)
    localparam int unsigned STAT_ALIGNED_BIT = 1;
    localparam int unsigned STAT_RFAULT_BIT  = 5;

    // Control register bit positions
    localparam int unsigned TXC_ENABLE_BIT   = 0;
    localparam int unsigned TXC_SEND_RFI_BIT = 4;
    localparam int unsigned RXC_ENABLE_BIT   = 0;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    // Floor on the number of idle clocks between status reads
    localparam int unsigned MIN_POLL_GAP = 16;

endpackage

// File: rtl/lbs_axil_master.sv
module lbs_axil_master
    import lbs_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    // command side
    input  logic                cmd_start,
    input  logic                cmd_write,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [DATA_W-1:0]   cmd_wdata,
    output logic                cmd_idle,
    output logic                cmd_done,
    output logic [1:0]          cmd_resp,
    output logic [DATA_W-1:0]   cmd_rdata,
    // AXI4-Lite master side
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [ADDR_W-1:0]   m_awaddr,
    output logic                m_wvalid,
    input  logic                m_wready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    input  logic                m_bvalid,
    output logic                m_bready,
    input  logic [1:0]          m_bresp,
    output logic                m_arvalid,
    input  logic                m_arready,
    output logic [ADDR_W-1:0]   m_araddr,
    input  logic                m_rvalid,
    output logic                m_rready,
    input  logic [DATA_W-1:0]   m_rdata,
    input  logic [1:0]          m_rresp
);

    axm_state_e          m_state;
    logic                is_wr;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;
    logic                aw_ok;
    logic                w_ok;
    logic                aw_hs;
    logic                w_hs;

    assign aw_hs = m_awvalid && m_awready;
    assign w_hs  = m_wvalid && m_wready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state <= M_IDLE;
            is_wr   <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            aw_ok   <= 1'b0;
            w_ok    <= 1'b0;
        end else begin
            unique case (m_state)
                M_IDLE: begin
                    if (cmd_start) begin
                        is_wr   <= cmd_write;
                        addr_q  <= cmd_addr;
                        data_q  <= cmd_wdata;
                        aw_ok   <= 1'b0;
                        w_ok    <= 1'b0;
                        m_state <= M_ADDR;
                    end
                end
                M_ADDR: begin
                    if (is_wr) begin
                        if ((aw_ok || aw_hs) && (w_ok || w_hs)) begin
                            m_state <= M_RESP;
                        end else begin
                            aw_ok <= aw_ok || aw_hs;
                            w_ok  <= w_ok || w_hs;
                        end
                    end else if (m_arready) begin
                        m_state <= M_RESP;
                    end
                end
                M_RESP: begin
                    if (cmd_done) begin
                        m_state <= M_IDLE;
                    end
                end
                default: m_state <= M_IDLE;
            endcase
        end
    end

    always_comb begin
        m_awvalid = (m_state == M_ADDR) && is_wr && !aw_ok;
        m_wvalid  = (m_state == M_ADDR) && is_wr && !w_ok;
        m_arvalid = (m_state == M_ADDR) && !is_wr;
        m_bready  = (m_state == M_RESP) && is_wr;
        m_rready  = (m_state == M_RESP) && !is_wr;
        m_awaddr  = addr_q;
        m_araddr  = addr_q;
        m_wdata   = data_q;
        m_wstrb   = '1;
        cmd_idle  = (m_state == M_IDLE);
        cmd_done  = (m_state == M_RESP) && (is_wr ? m_bvalid : m_rvalid);
        cmd_resp  = is_wr ? m_bresp : m_rresp;
        cmd_rdata = m_rdata;
    end

endmodule

// File: rtl/lbs_poll_timer.sv
module lbs_poll_timer
    import lbs_pkg::*;
#(
    parameter int unsigned GAP_CYCLES = 64,
    parameter int unsigned POLL_LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gap_run,
    input  logic poll_clr,
    input  logic poll_inc,
    output logic gap_done,
    output logic poll_last
);

    localparam int unsigned GAP_EFF  = (GAP_CYCLES < MIN_POLL_GAP) ? MIN_POLL_GAP : GAP_CYCLES;
    localparam int unsigned GAP_W    = $clog2(GAP_EFF);
    localparam int unsigned LIM_EFF  = (POLL_LIMIT < 1) ? 1 : POLL_LIMIT;
    localparam int unsigned POLL_W   = $clog2(LIM_EFF + 1);

    logic [GAP_W-1:0]  gap_cnt;
    logic [POLL_W-1:0] poll_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (!gap_run) begin
            gap_cnt <= '0;
        end else if (gap_cnt != GAP_W'(GAP_EFF - 1)) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_cnt <= '0;
        end else if (poll_clr) begin
            poll_cnt <= '0;
        end else if (poll_inc && !poll_last) begin
            poll_cnt <= poll_cnt + 1'b1;
        end
    end

    assign gap_done  = gap_run && (gap_cnt == GAP_W'(GAP_EFF - 1));
    assign poll_last = (poll_cnt == POLL_W'(LIM_EFF - 1));

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
    import lbs_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned TX_CTRL_OFS = 'h000C,
    parameter int unsigned RX_CTRL_OFS = 'h0014,
    parameter int unsigned RX_STAT_OFS = 'h0204,
    parameter int unsigned POLL_GAP    = 64,
    parameter int unsigned POLL_LIMIT  = 1000
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [ADDR_W-1:0]   m_awaddr,
    output logic                m_wvalid,
    input  logic                m_wready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    input  logic                m_bvalid,
    output logic                m_bready,
    input  logic [1:0]          m_bresp,
    output logic                m_arvalid,
    input  logic                m_arready,
    output logic [ADDR_W-1:0]   m_araddr,
    input  logic                m_rvalid,
    output logic                m_rready,
    input  logic [DATA_W-1:0]   m_rdata,
    input  logic [1:0]          m_rresp,
    output logic                link_up,
    output logic                link_fault,
    output logic [DATA_W-1:0]   last_status
);

    localparam logic [ADDR_W-1:0] TXC_ADDR  = ADDR_W'(TX_CTRL_OFS);
    localparam logic [ADDR_W-1:0] RXC_ADDR  = ADDR_W'(RX_CTRL_OFS);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(RX_STAT_OFS);
    localparam logic [DATA_W-1:0] TXC_FORCE_RFI = DATA_W'(1) << TXC_SEND_RFI_BIT;
    localparam logic [DATA_W-1:0] TXC_RUN       = DATA_W'(1) << TXC_ENABLE_BIT;
    localparam logic [DATA_W-1:0] RXC_RUN       = DATA_W'(1) << RXC_ENABLE_BIT;

    seq_state_e          state;
    seq_state_e          state_nx;
    logic                cmd_sent;
    logic                cmd_start;
    logic                cmd_write;
    logic [ADDR_W-1:0]   cmd_addr;
    logic [DATA_W-1:0]   cmd_wdata;
    logic                cmd_idle;
    logic                cmd_done;
    logic [1:0]          cmd_resp;
    logic [DATA_W-1:0]   cmd_rdata;
    logic                op_state;
    logic                rd_state;
    logic                wr_ok;
    logic                st_aligned;
    logic                st_rfault;
    logic                gap_run;
    logic                gap_done;
    logic                poll_clr;
    logic                poll_inc;
    logic                poll_last;
    logic                fault_set;

    // ---------------------------------------------------------------
    // Transaction engine and poll timing
    // ---------------------------------------------------------------
    lbs_axil_master #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_axm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .cmd_idle  (cmd_idle),
        .cmd_done  (cmd_done),
        .cmd_resp  (cmd_resp),
        .cmd_rdata (cmd_rdata),
        .m_awvalid (m_awvalid),
        .m_awready (m_awready),
        .m_awaddr  (m_awaddr),
        .m_wvalid  (m_wvalid),
        .m_wready  (m_wready),
        .m_wdata   (m_wdata),
        .m_wstrb   (m_wstrb),
        .m_bvalid  (m_bvalid),
        .m_bready  (m_bready),
        .m_bresp   (m_bresp),
        .m_arvalid (m_arvalid),
        .m_arready (m_arready),
        .m_araddr  (m_araddr),
        .m_rvalid  (m_rvalid),
        .m_rready  (m_rready),
        .m_rdata   (m_rdata),
        .m_rresp   (m_rresp)
    );

    lbs_poll_timer #(
        .GAP_CYCLES (POLL_GAP),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .gap_run   (gap_run),
        .poll_clr  (poll_clr),
        .poll_inc  (poll_inc),
        .gap_done  (gap_done),
        .poll_last (poll_last)
    );

    // ---------------------------------------------------------------
    // Per-state command selection
    // ---------------------------------------------------------------
    always_comb begin
        op_state  = 1'b0;
        rd_state  = 1'b0;
        cmd_write = 1'b0;
        cmd_addr  = STAT_ADDR;
        cmd_wdata = '0;
        unique case (state)
            S_TX_RFI, S_TX_DROP: begin
                op_state  = 1'b1;
                cmd_write = 1'b1;
                cmd_addr  = TXC_ADDR;
                cmd_wdata = TXC_FORCE_RFI;
            end
            S_RX_EN: begin
                op_state  = 1'b1;
                cmd_write = 1'b1;
                cmd_addr  = RXC_ADDR;
                cmd_wdata = RXC_RUN;
            end
            S_TX_EN: begin
                op_state  = 1'b1;
                cmd_write = 1'b1;
                cmd_addr  = TXC_ADDR;
                cmd_wdata = TXC_RUN;
            end
            S_ALIGN_RD, S_RF_RD, S_UP_RD: begin
                op_state = 1'b1;
                rd_state = 1'b1;
            end
            default: ;
        endcase
    end

    assign cmd_start  = op_state && !cmd_sent && cmd_idle;
    assign wr_ok      = (cmd_resp == RESP_OKAY);
    assign st_aligned = cmd_rdata[STAT_ALIGNED_BIT];
    assign st_rfault  = cmd_rdata[STAT_RFAULT_BIT];

    assign gap_run  = (state == S_ALIGN_GAP) || (state == S_RF_GAP) || (state == S_UP_GAP);
    assign poll_clr = (state == S_RESET) || (state == S_RX_EN) || (state == S_TX_EN) ||
                      (state == S_TX_DROP) || (state == S_UP_GAP);
    assign poll_inc = cmd_done && ((state == S_ALIGN_RD) || (state == S_RF_RD));

    // ---------------------------------------------------------------
    // Next-state logic
    // ---------------------------------------------------------------
    always_comb begin
        state_nx  = state;
        fault_set = 1'b0;
        unique case (state)
            S_RESET: state_nx = S_TX_RFI;
            S_TX_RFI: begin
                if (cmd_done) begin
                    state_nx  = wr_ok ? S_RX_EN : S_RESET;
                    fault_set = !wr_ok;
                end
            end
            S_RX_EN: begin
                if (cmd_done) begin
                    state_nx  = wr_ok ? S_ALIGN_GAP : S_RESET;
                    fault_set = !wr_ok;
                end
            end
            S_ALIGN_GAP: begin
                if (gap_done) state_nx = S_ALIGN_RD;
            end
            S_ALIGN_RD: begin
                if (cmd_done) begin
                    if (st_aligned) begin
                        state_nx = S_TX_EN;
                    end else if (poll_last) begin
                        state_nx  = S_RESET;
                        fault_set = 1'b1;
                    end else begin
                        state_nx = S_ALIGN_GAP;
                    end
                end
            end
            S_TX_EN: begin
                if (cmd_done) begin
                    state_nx  = wr_ok ? S_RF_GAP : S_RESET;
                    fault_set = !wr_ok;
                end
            end
            S_RF_GAP: begin
                if (gap_done) state_nx = S_RF_RD;
            end
            S_RF_RD: begin
                if (cmd_done) begin
                    if (!st_aligned) begin
                        state_nx = S_TX_DROP;
                    end else if (!st_rfault) begin
                        state_nx = S_UP_GAP;
                    end else if (poll_last) begin
                        state_nx  = S_RESET;
                        fault_set = 1'b1;
                    end else begin
                        state_nx = S_RF_GAP;
                    end
                end
            end
            S_UP_GAP: begin
                if (gap_done) state_nx = S_UP_RD;
            end
            S_UP_RD: begin
                if (cmd_done) begin
                    state_nx = st_aligned ? S_UP_GAP : S_TX_DROP;
                end
            end
            S_TX_DROP: begin
                if (cmd_done) begin
                    state_nx  = wr_ok ? S_ALIGN_GAP : S_RESET;
                    fault_set = !wr_ok;
                end
            end
            default: state_nx = S_RESET;
        endcase
    end

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_RESET;
            cmd_sent <= 1'b0;
        end else begin
            state <= state_nx;
            if (state_nx != state) begin
                cmd_sent <= 1'b0;
            end else if (cmd_start) begin
                cmd_sent <= 1'b1;
            end
        end
    end

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_up     <= 1'b0;
            link_fault  <= 1'b0;
            last_status <= '0;
        end else begin
            if (cmd_done && rd_state) begin
                last_status <= cmd_rdata;
            end
            if (fault_set) begin
                link_fault <= 1'b1;
            end
            if ((state == S_RF_RD) && (state_nx == S_UP_GAP)) begin
                link_up <= 1'b1;
            end else if ((state_nx == S_TX_DROP) || (state_nx == S_RESET)) begin
                link_up <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned RX_STAT_OFS = 'h0204,
    parameter int unsigned MIN_GAP     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_awvalid,
    input logic              m_awready,
    input logic [ADDR_W-1:0] m_awaddr,
    input logic              m_wvalid,
    input logic              m_wready,
    input logic [DATA_W-1:0] m_wdata,
    input logic              m_bvalid,
    input logic              m_bready,
    input logic [1:0]        m_bresp,
    input logic              m_arvalid,
    input logic              m_arready,
    input logic [ADDR_W-1:0] m_araddr,
    input logic              m_rvalid,
    input logic              m_rready,
    input logic              rd_aligned,
    input logic              rd_rfault,
    input logic              link_up,
    input logic              link_fault
);

    logic [7:0] gap_cnt;
    logic       seen_ar;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= '0;
            seen_ar <= 1'b0;
        end else if (m_arvalid && m_arready) begin
            gap_cnt <= '0;
            seen_ar <= 1'b1;
        end else if (gap_cnt != 8'hFF) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!link_up && !link_fault && !m_awvalid && !m_wvalid && !m_arvalid));

    a_r3_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid |-> (m_araddr == ADDR_W'(RX_STAT_OFS)));

    a_r6_up_after_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> $past(m_rvalid && m_rready && rd_aligned && !rd_rfault));

    a_r7_poll_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && m_arready && seen_ar) |-> (gap_cnt >= 8'(MIN_GAP)));

    a_r9_bad_bresp: assert property (@(posedge clk) disable iff (!rst_n)
        (m_bvalid && m_bready && (m_bresp != 2'b00)) |=> link_fault);

    a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        link_fault |=> link_fault);

    a_r11_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

    a_r11_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata)));

    a_r11_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));

    a_r11_aw_w_together: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_awvalid) |-> m_wvalid);

    a_r11_single_txn: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_arvalid && (m_awvalid || m_wvalid)));

    a_r12_drop_on_misalign: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && m_rvalid && m_rready && !rd_aligned) |=> !link_up);

endmodule

bind link_bringup_seq lbs_checker #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .RX_STAT_OFS (RX_STAT_OFS),
    .MIN_GAP     (16)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .m_awvalid  (m_awvalid),
    .m_awready  (m_awready),
    .m_awaddr   (m_awaddr),
    .m_wvalid   (m_wvalid),
    .m_wready   (m_wready),
    .m_wdata    (m_wdata),
    .m_bvalid   (m_bvalid),
    .m_bready   (m_bready),
    .m_bresp    (m_bresp),
    .m_arvalid  (m_arvalid),
    .m_arready  (m_arready),
    .m_araddr   (m_araddr),
    .m_rvalid   (m_rvalid),
    .m_rready   (m_rready),
    .rd_aligned (m_rdata[1]),
    .rd_rfault  (m_rdata[5]),
    .link_up    (link_up),
    .link_fault (link_fault)
);

// File: tb/link_bringup_seq_tb.sv
module link_bringup_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_awvalid, m_awready;
    logic [15:0] m_awaddr;
    logic        m_wvalid, m_wready;
    logic [31:0] m_wdata;
    logic [3:0]  m_wstrb;
    logic        m_bvalid, m_bready;
    logic [1:0]  m_bresp;
    logic        m_arvalid, m_arready;
    logic [15:0] m_araddr;
    logic        m_rvalid, m_rready;
    logic [31:0] m_rdata;
    logic [1:0]  m_rresp;
    logic        link_up, link_fault;
    logic [31:0] last_status;

    always #2.5 clk = ~clk;

    link_bringup_seq #(
        .POLL_GAP   (16),
        .POLL_LIMIT (8)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata), .m_rresp(m_rresp),
        .link_up(link_up), .link_fault(link_fault), .last_status(last_status)
    );

    // ---------------- register model of the MAC core ----------------
    logic [31:0] stat_word = 32'h0;
    logic        inj_armed = 1'b0;
    logic [15:0] inj_addr = 16'h0;
    logic        inj_used;
    logic        aw_got, w_got;
    logic [15:0] aw_addr_q;
    logic [31:0] w_data_q;
    int          w_lag;
    logic [31:0] tx_ctrl, rx_ctrl;
    logic [15:0] log_addr [16];
    logic [31:0] log_data [16];
    int          wr_cnt, rd_cnt, wr_at_first_rd;
    longint      cyc = 0;
    longint      last_ar_cyc = 0;
    longint      min_gap = 1000000;
    int          total_reads = 0;
    int          viol = 0;
    int          bad_addr = 0;
    logic        pend_aw, pend_w, pend_ar;
    logic [15:0] pend_aw_addr, pend_ar_addr;
    logic [31:0] pend_w_data;
    logic        prev_awvalid;

    assign m_rresp = 2'b00;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_awready <= 0; m_wready <= 0; m_arready <= 0;
            m_bvalid <= 0; m_bresp <= 0; m_rvalid <= 0; m_rdata <= 0;
            aw_got <= 0; w_got <= 0; aw_addr_q <= 0; w_data_q <= 0; w_lag <= 0;
            tx_ctrl <= 0; rx_ctrl <= 0; wr_cnt <= 0; rd_cnt <= 0; wr_at_first_rd <= -1;
            inj_used <= 0;
            pend_aw <= 0; pend_w <= 0; pend_ar <= 0;
            pend_aw_addr <= 0; pend_ar_addr <= 0; pend_w_data <= 0; prev_awvalid <= 0;
        end else begin
            // write address: ready one cycle after valid
            m_awready <= m_awvalid && !m_awready && !aw_got;
            if (m_awvalid && m_awready) begin
                aw_got <= 1; aw_addr_q <= m_awaddr;
            end
            // write data: ready two cycles after valid
            if (m_wvalid && !m_wready && !w_got) w_lag <= w_lag + 1; else w_lag <= 0;
            m_wready <= m_wvalid && !m_wready && !w_got && (w_lag >= 1);
            if (m_wvalid && m_wready) begin
                w_got <= 1; w_data_q <= m_wdata;
            end
            if (aw_got && w_got && !m_bvalid) begin
                m_bvalid <= 1;
                if (inj_armed && !inj_used && aw_addr_q == inj_addr) begin
                    m_bresp <= 2'b10; inj_used <= 1;
                end else begin
                    m_bresp <= 2'b00;
                end
            end
            if (m_bvalid && m_bready) begin
                m_bvalid <= 0; aw_got <= 0; w_got <= 0;
                if (aw_addr_q == 16'h000C) tx_ctrl <= w_data_q;
                if (aw_addr_q == 16'h0014) rx_ctrl <= w_data_q;
                if (wr_cnt < 16) begin
                    log_addr[wr_cnt] <= aw_addr_q; log_data[wr_cnt] <= w_data_q;
                end
                wr_cnt <= wr_cnt + 1;
            end
            // read channel
            m_arready <= m_arvalid && !m_arready;
            if (m_arvalid && m_arready) begin
                m_rvalid <= 1;
                m_rdata <= (m_araddr == 16'h0204) ? stat_word : 32'h0;
                if (m_araddr != 16'h0204) bad_addr <= bad_addr + 1;
                if (rd_cnt == 0) wr_at_first_rd <= wr_cnt;
                else if (cyc - last_ar_cyc < min_gap) min_gap <= cyc - last_ar_cyc;
                last_ar_cyc <= cyc;
                rd_cnt <= rd_cnt + 1;
                total_reads <= total_reads + 1;
            end
            if (m_rvalid && m_rready) m_rvalid <= 0;
            // protocol monitor
            if (pend_aw && (!m_awvalid || m_awaddr != pend_aw_addr)) viol <= viol + 1;
            else if (pend_w && (!m_wvalid || m_wdata != pend_w_data)) viol <= viol + 1;
            else if (pend_ar && (!m_arvalid || m_araddr != pend_ar_addr)) viol <= viol + 1;
            else if (m_awvalid && !prev_awvalid && !m_wvalid) viol <= viol + 1;
            else if (m_arvalid && (m_awvalid || m_wvalid)) viol <= viol + 1;
            pend_aw <= m_awvalid && !m_awready; pend_aw_addr <= m_awaddr;
            pend_w  <= m_wvalid && !m_wready;   pend_w_data  <= m_wdata;
            pend_ar <= m_arvalid && !m_arready; pend_ar_addr <= m_araddr;
            prev_awvalid <= m_awvalid;
        end
    end

    // ---------------- checking ----------------
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [31:0] st);
        @(negedge clk);
        stat_word = st;
        rst_n = 0;
        wait_cyc(4);
        rst_n = 1;
    endtask

    // {status[15:0], expected TX control[7:0], expected link_up[7:0]}
    localparam logic [31:0] VEC [8] = '{
        {16'h00C0, 8'h10, 8'h00},
        {16'h00E0, 8'h10, 8'h00},
        {16'h0023, 8'h01, 8'h00},
        {16'h0003, 8'h01, 8'h01},
        {16'h0002, 8'h01, 8'h01},
        {16'h0001, 8'h10, 8'h00},
        {16'hFFFD, 8'h10, 8'h00},
        {16'h0022, 8'h01, 8'h00}
    };

    initial begin
        // R1: reset state
        wait_cyc(2);
        check(link_up == 0, "R1 link_up in reset", link_up, 0);
        check(link_fault == 0, "R1 link_fault in reset", link_fault, 0);
        check(last_status == 0, "R1 last_status in reset", last_status, 0);
        check(!m_awvalid && !m_wvalid && !m_arvalid, "R1 valids in reset",
              {m_awvalid, m_wvalid, m_arvalid}, 0);

        // R4 / R6 / R3: status pattern table
        for (int i = 0; i < 8; i++) begin
            do_reset({16'h0, VEC[i][31:16]});
            wait_cyc(120);
            check(tx_ctrl == {24'h0, VEC[i][15:8]}, "R4 TX control after pattern", tx_ctrl, VEC[i][15:8]);
            check(link_up == VEC[i][0], "R6 link_up after pattern", link_up, VEC[i][0]);
            check(last_status == {16'h0, VEC[i][31:16]}, "R3 last_status", last_status, VEC[i][31:16]);
            check(link_fault == 0, "R8 no early fault", link_fault, 0);
        end

        // R2 / R5: write order on a clean bring-up
        do_reset(32'h0003);
        wait_cyc(120);
        check(log_addr[0] == 16'h000C && log_data[0] == 32'h10, "R2 first write", {log_addr[0], log_data[0]}, {16'h000C, 32'h10});
        check(log_addr[1] == 16'h0014 && log_data[1] == 32'h01, "R2 second write", {log_addr[1], log_data[1]}, {16'h0014, 32'h01});
        check(wr_at_first_rd == 2, "R2 writes before first read", wr_at_first_rd, 2);
        check(log_addr[2] == 16'h000C && log_data[2] == 32'h01, "R5 release write", {log_addr[2], log_data[2]}, {16'h000C, 32'h01});
        check(wr_cnt == 3, "R5 write count", wr_cnt, 3);
        check(link_up == 1, "R6 link up", link_up, 1);

        // R12: alignment lost while up, then regained
        stat_word = 32'h00C0;
        wait_cyc(50);
        check(link_up == 0, "R12 link down", link_up, 0);
        check(tx_ctrl == 32'h10, "R12 RFI reasserted", tx_ctrl, 32'h10);
        stat_word = 32'h0003;
        wait_cyc(80);
        check(link_up == 1, "R12 link regained", link_up, 1);

        // R6: lingering remote fault keeps link down
        do_reset(32'h0023);
        for (int k = 0; k < 200 && tx_ctrl != 32'h01; k++) @(negedge clk);
        wait_cyc(80);
        check(link_up == 0, "R6 held down by remote fault", link_up, 0);
        check(last_status == 32'h23, "R6 still polling", last_status, 32'h23);
        stat_word = 32'h0003;
        wait_cyc(50);
        check(link_up == 1, "R6 up after fault clears", link_up, 1);

        // R8 / R10: timeout in alignment phase
        do_reset(32'h00C0);
        wait_cyc(300);
        check(link_fault == 1, "R8 timeout fault", link_fault, 1);
        check(wr_cnt >= 3 && log_addr[2] == 16'h000C && log_data[2] == 32'h10, "R8 restart write",
              {log_addr[2], log_data[2]}, {16'h000C, 32'h10});
        stat_word = 32'h0003;
        wait_cyc(120);
        check(link_up == 1, "R10 up after restart", link_up, 1);
        check(link_fault == 1, "R10 fault sticky", link_fault, 1);

        // R9 / R10: bad write response on RX control
        inj_addr = 16'h0014;
        inj_armed = 1;
        do_reset(32'h0003);
        wait_cyc(30);
        inj_armed = 0;
        check(link_fault == 1, "R9 bad response fault", link_fault, 1);
        wait_cyc(30);
        check(log_addr[2] == 16'h000C && log_data[2] == 32'h10, "R9 restart write",
              {log_addr[2], log_data[2]}, {16'h000C, 32'h10});
        wait_cyc(120);
        check(link_up == 1 && link_fault == 1, "R10 up with fault kept", {link_up, link_fault}, 2'b11);

        // R7 / R11 / R3: whole-run protocol observations
        check(total_reads > 10 && min_gap >= 16, "R7 poll spacing", min_gap, 16);
        check(viol == 0, "R11 handshake violations", viol, 0);
        check(bad_addr == 0, "R3 read address", bad_addr, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule